// File: doc/BRIEF.md
# Nibble-Wide Transmit Framer with Carrier Deferral

This block is the transmit side of an Ethernet MAC for a 4-bit media independent interface. Frame bytes come in on a valid/ready byte stream with a last-byte marker and an error marker. The block wraps each frame in a preamble and start delimiter, sends every byte as two nibbles, and appends a 32-bit check sequence. All outputs are timed by the clock that the PHY supplies. No state depends on that clock's rate, so the clock may run at 25 MHz or 2.5 MHz and may stop for any length of time.

The block has no error pin toward the PHY. A frame with a flagged error, or a frame whose source runs dry part way through, is closed with the bitwise complement of its correct check sequence, and the receiver discards it. Between frames the block holds an inter-packet gap. In full duplex the gap timer runs from the end of the block's own transmission and the carrier input is ignored. In half duplex the block defers to carrier: the gap is counted only while carrier is low, and any carrier restarts the count.

Top module: `mii_tx_framer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `tx_en` is 0, `txd` is 0 and `in_ready` is 0.
- R2: The first 16 nibbles of every frame are fifteen nibbles of 0x5 followed by one nibble of 0xD. The first nibble with `tx_en` high is 0x5.
- R3: `tx_en` stays high without a break over the preamble, the data and the check sequence, which is 16 + 2·N + 8 cycles for N sent bytes. Each byte goes out low nibble first (`txd` = bits 3:0), then high nibble (bits 7:4). A one-byte frame is valid.
- R4: The check sequence is the IEEE 802.3 CRC-32 over the data bytes only (polynomial 0x04C11DB7, preset all-ones, result complemented). It is sent in 8 nibbles, least significant nibble first. For the nine bytes "123456789" the value is 0xCBF43926, so the nibbles are 6,2,9,3,4,F,B,C.
- R5: When any accepted byte of a frame has `in_err` high, the byte is still sent, and the check sequence of that frame is the bitwise inverse of the R4 value.
- R6: When `in_ready` is high and `in_valid` is low in the middle of a frame, the frame ends after the bytes already accepted, with the inverted check sequence.
- R7: Between two frames `tx_en` is low for at least 24 qualifying cycles. When the next frame is already waiting, it starts after exactly 24.
- R8: With `full_duplex` = 1, `crs` has no effect. Back-to-back frames are separated by exactly 24 low cycles, whatever the level of `crs`.
- R9: With `full_duplex` = 0, no frame starts in a cycle where `crs` is sampled high, and a high `crs` resets the gap count. A waiting frame starts exactly 24 cycles after `crs` falls.
- R10: `in_ready` is high only while a frame is being sent: in the last preamble cycle, and in the high-nibble cycle of each byte not marked last.
- R11: Stopping `tx_clk` for any time leaves `txd` and `tx_en` unchanged, and the frame continues correctly once the clock resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock from the PHY |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex with carrier deferral |
| crs | input | 1 | Carrier sense from the PHY |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 1 | Marks the byte as carrying a transmit error |
| in_ready | output | 1 | Byte accepted at the next edge when in_valid is high |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable, high while txd carries frame nibbles |

## Verification
Two functions can fall in the same cycle: the end of the gap timer, and the start of the next frame that is already waiting. In half duplex, carrier can also arrive in the same cycle that would otherwise have completed the gap. These cases are provoked by offering the next frame while the previous check sequence is still going out, and by raising carrier for a few cycles inside the gap. A behavioural reference in the bench counts qualifying low cycles on its own. It also rebuilds every expected nibble with an MSB-first CRC and compares `txd` on every clock. Each start is then judged against a gap of exactly 24 and against the carrier level sampled at that edge.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_DATA = 3'd2,
    ST_FCS  = 3'd3,
    ST_GAP  = 3'd4
  } tx_state_e;

  localparam int FCS_NIBBLES = 8;
  localparam int BYTE_W      = 8;

endpackage

// File: rtl/mii_tx_crc.sv
module mii_tx_crc #(
  parameter int          CRC_W     = 32,
  parameter int          DATA_W    = 8,
  parameter logic [31:0] POLY_REFL = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              upd,
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc_q
);

  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] step_v;

  // reflected shift register, data bits taken LSB first
  always_comb begin
    step_v = crc_q;
    for (int i = 0; i < DATA_W; i++) begin
      if (step_v[0] ^ data[i]) step_v = (step_v >> 1) ^ POLY_REFL[CRC_W-1:0];
      else                     step_v = step_v >> 1;
    end
    crc_d = crc_q;
    if (init)     crc_d = '1;
    else if (upd) crc_d = step_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            crc_q <= '1;
    else if (init || upd)  crc_q <= crc_d;
  end

  assert_crc_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == '1));

endmodule

// File: rtl/mii_tx_gap.sv
module mii_tx_gap #(
  parameter int GAP_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic hold,
  output logic done
);

  localparam int CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done = run && !hold && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (restart) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (run) begin
      cnt_en = 1'b1;
      if (hold)               cnt_d = '0;
      else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_gap_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_gap_carrier_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold && !restart) |=> (cnt_q == '0));

endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mii_tx_pkg::*;
#(
  parameter int         PRE_NIBBLES = 16,
  parameter int         GAP_CYCLES  = 24,
  parameter logic [3:0] PRE_NIB     = 4'h5,
  parameter logic [3:0] SFD_NIB     = 4'hD
) (
  input  logic       tx_clk,
  input  logic       rst_n,
  input  logic       full_duplex,
  input  logic       crs,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_err,
  output logic       in_ready,
  output logic [3:0] txd,
  output logic       tx_en
);

  localparam int CNT_W = (PRE_NIBBLES > FCS_NIBBLES) ? $clog2(PRE_NIBBLES) : $clog2(FCS_NIBBLES);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_NIBBLES - 1);
  localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_NIBBLES - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge tx_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] byte_q;
  logic              last_q, err_q, err_d;
  logic              accept, underrun, start;
  logic              crc_init;
  logic [31:0]       crc_q, fcs_word;
  logic              gap_restart, gap_run, gap_hold, gap_done;

  assign in_ready = ((state_q == ST_PRE)  && (cnt_q == PRE_LAST)) ||
                    ((state_q == ST_DATA) && cnt_q[0] && !last_q);
  assign accept   = in_ready && in_valid;
  assign underrun = in_ready && !in_valid;
  assign gap_hold = !full_duplex && crs;
  assign gap_run  = (state_q == ST_GAP);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    start    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (gap_hold)      state_d = ST_GAP;
        else if (in_valid) start   = 1'b1;
      end
      ST_PRE: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == PRE_LAST) begin
          cnt_d   = '0;
          state_d = underrun ? ST_FCS : ST_DATA;
        end
      end
      ST_DATA: begin
        if (!cnt_q[0]) cnt_d = CNT_W'(1);
        else begin
          cnt_d = '0;
          if (last_q || underrun) state_d = ST_FCS;
        end
      end
      ST_FCS: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == FCS_LAST) state_d = ST_GAP;
      end
      ST_GAP: begin
        if (gap_done) begin
          if (in_valid) start   = 1'b1;
          else          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (start) begin
      state_d = ST_PRE;
      cnt_d   = '0;
      err_d   = 1'b0;
    end
    if (underrun)             err_d = 1'b1;
    if (accept && in_err)     err_d = 1'b1;
  end

  assign crc_init    = start;
  assign gap_restart = (state_d == ST_GAP) && (state_q != ST_GAP);

  always_ff @(posedge tx_clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  // byte holding register, loaded only on an accepted byte
  always_ff @(posedge tx_clk or negedge rst_sn) begin
    if (!rst_sn) begin
      byte_q <= '0;
      last_q <= 1'b0;
    end else if (accept) begin
      byte_q <= in_data;
      last_q <= in_last;
    end
  end

  mii_tx_crc #(.CRC_W(32), .DATA_W(BYTE_W)) u_crc (
    .clk   (tx_clk),
    .rst_n (rst_sn),
    .init  (crc_init),
    .upd   (accept),
    .data  (in_data),
    .crc_q (crc_q)
  );

  mii_tx_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk     (tx_clk),
    .rst_n   (rst_sn),
    .restart (gap_restart),
    .run     (gap_run),
    .hold    (gap_hold),
    .done    (gap_done)
  );

  // errored frame: send the raw register, the inverse of the good sequence
  assign fcs_word = err_q ? crc_q : ~crc_q;

  always_comb begin
    txd   = 4'h0;
    tx_en = 1'b0;
    unique case (state_q)
      ST_PRE: begin
        tx_en = 1'b1;
        txd   = (cnt_q == PRE_LAST) ? SFD_NIB : PRE_NIB;
      end
      ST_DATA: begin
        tx_en = 1'b1;
        txd   = cnt_q[0] ? byte_q[7:4] : byte_q[3:0];
      end
      ST_FCS: begin
        tx_en = 1'b1;
        txd   = fcs_word[{cnt_q[2:0], 2'b00} +: 4];
      end
      default: ;
    endcase
  end

  assert_ready_in_frame_R10: assert property (@(posedge tx_clk) disable iff (!rst_sn)
    in_ready |-> tx_en);

  assert_first_nibble_R2: assert property (@(posedge tx_clk) disable iff (!rst_sn)
    $rose(tx_en) |-> (txd == PRE_NIB));

  assert_defer_carrier_R9: assert property (@(posedge tx_clk) disable iff (!rst_sn)
    (!full_duplex && crs && !tx_en) |=> !tx_en);

  assert_fcs_length_R4: assert property (@(posedge tx_clk) disable iff (!rst_sn)
    $fell(tx_en) |-> ($past(cnt_q) == FCS_LAST));

endmodule

// File: tb/test_mii_tx_framer.sv
module test_mii_tx_framer;

  logic       tx_clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n, full_duplex, crs, in_valid, in_last, in_err;
  logic [7:0] in_data;
  logic       in_ready, tx_en;
  logic [3:0] txd;

  int vectors = 0;
  int miscompares = 0;

  mii_tx_framer i_mii_tx_framer (
    .tx_clk(tx_clk), .rst_n(rst_n), .full_duplex(full_duplex), .crs(crs),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready), .txd(txd), .tx_en(tx_en)
  );

  always begin
    #5;
    if (clk_run) tx_clk = ~tx_clk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  // reference model state
  logic [3:0] exp_q[$];
  string      tag_q[$];
  int         len_q[$];
  logic [3:0] act_q[$];
  logic [7:0] fr [0:31];
  bit         mon_on = 1'b0;
  bit         prev_en = 1'b0;
  bit         took = 1'b0;
  int         fidx = 0;
  int         elig = 1000;
  int         low_total = 0;
  int         last_gap = 0;
  int         last_low = 0;

  always @(posedge tx_clk) took <= in_valid && in_ready;

  always @(negedge tx_clk) begin
    if (mon_on) begin
      if (in_ready && !tx_en) chk(1'b0, "R10 ready outside frame", 1, 0);
      if (tx_en) begin
        if (!prev_en) begin
          act_q.delete();
          fidx = 0;
          last_gap = (!full_duplex && crs) ? 0 : elig + 1;
          last_low = low_total;
          chk(!(!full_duplex && crs), "R9 start under carrier", crs, 0);
          chk(last_gap >= 24, "R7 gap too short", last_gap, 24);
        end
        act_q.push_back(txd);
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected nibble", txd, 0);
        else begin
          logic [3:0] n;
          string t;
          n = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(txd === n, t, txd, n);
        end
        fidx++;
      end else begin
        if (prev_en) begin
          int l;
          l = (len_q.size() != 0) ? len_q.pop_front() : -1;
          chk(fidx == l, "R3 frame length", fidx, l);
          elig = 0;
          low_total = 1;
        end else begin
          if (!full_duplex && crs) elig = 0;
          else                     elig++;
          low_total++;
        end
      end
      prev_en = tx_en;
    end
  end

  task automatic step();
    @(negedge tx_clk);
    #1;
  endtask

  function automatic void push(input logic [3:0] n, input string t);
    exp_q.push_back(n);
    tag_q.push_back(t);
  endfunction

  // MSB-first CRC on bits in wire order, independent of the reflected form
  task automatic build(input int n, input int err_idx, input int ur_k);
    logic [31:0] c;
    int m;
    bit bad;
    m = (ur_k >= 0) ? ur_k : n;
    bad = (ur_k >= 0) || (err_idx >= 0 && err_idx < m);
    for (int i = 0; i < 15; i++) push(4'h5, "R2 preamble");
    push(4'hD, "R2 delimiter");
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < m; i++) begin
      push(fr[i][3:0], "R3 low nibble");
      push(fr[i][7:4], "R3 high nibble");
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[31] ^ fr[i][b];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
    end
    for (int k = 0; k < 8; k++) begin
      logic [3:0] nb;
      for (int j = 0; j < 4; j++) nb[j] = bad ? c[31-4*k-j] : ~c[31-4*k-j];
      push(nb, bad ? ((ur_k >= 0) ? "R6 underrun fcs" : "R5 inverted fcs") : "R4 fcs");
    end
    len_q.push_back(16 + 2*m + 8);
  endtask

  task automatic drive(input int n, input int err_idx, input int ur_k);
    int i = 0;
    int lim;
    lim = (ur_k >= 0) ? ur_k : n;
    while (i < lim) begin
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (ur_k < 0) && (i == n - 1);
      in_err   = (i == err_idx);
      step();
      if (took) i++;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_err   = 1'b0;
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) fr[i] = 8'((seed * 37 + i * 53 + 11) & 8'hFF);
  endtask

  task automatic wait_idle();
    int guard = 0;
    step();
    while ((exp_q.size() != 0 || tx_en) && guard < 3000) begin
      step();
      guard++;
    end
    chk(guard < 3000, "R3 frame never finished", guard, 0);
  endtask

  initial begin
    logic [3:0] anchor [8];
    logic [3:0] hold_txd;
    logic       hold_en;
    anchor = '{4'h6, 4'h2, 4'h9, 4'h3, 4'h4, 4'hF, 4'hB, 4'hC};
    rst_n = 1'b0; full_duplex = 1'b1; crs = 1'b0;
    in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0; in_err = 1'b0;
    repeat (3) step();
    chk(tx_en == 1'b0 && txd == 4'h0 && in_ready == 1'b0, "R1 in reset", {tx_en, txd, in_ready}, 0);
    rst_n = 1'b1;
    step();
    chk(tx_en == 1'b0 && txd == 4'h0 && in_ready == 1'b0, "R1 after release", {tx_en, txd, in_ready}, 0);
    repeat (3) step();
    mon_on = 1'b1;

    // R4 anchor frame, full duplex with carrier high (R8)
    crs = 1'b1;
    for (int i = 0; i < 9; i++) fr[i] = 8'h31 + 8'(i);
    build(9, -1, -1);
    drive(9, -1, -1);
    wait_idle();
    for (int k = 0; k < 8; k++)
      chk(act_q.size() == 42 && act_q[34+k] == anchor[k], "R4 check value 0xCBF43926", act_q[34+k], anchor[k]);

    // back-to-back frames, full duplex, carrier held high (R7, R8)
    fill(5, 1); build(5, -1, -1); drive(5, -1, -1);
    fill(3, 2); build(3, -1, -1); drive(3, -1, -1);
    wait_idle();
    chk(last_gap == 24, "R8 gap ignores carrier", last_gap, 24);
    chk(last_low == 24, "R7 exact low cycles", last_low, 24);
    crs = 1'b0;

    // flagged error (R5), underrun (R6), single byte (R3)
    fill(6, 3); build(6, 2, -1); drive(6, 2, -1); wait_idle();
    fill(8, 4); build(8, -1, 3); drive(8, -1, 3); wait_idle();
    fill(1, 5); build(1, -1, -1); drive(1, -1, -1); wait_idle();
    chk(last_gap >= 24, "R3 single byte after gap", last_gap, 24);

    // half duplex deferral (R9)
    full_duplex = 1'b0;
    crs = 1'b1;
    fill(4, 6); build(4, -1, -1);
    fork
      drive(4, -1, -1);
      begin
        repeat (30) step();
        chk(tx_en == 1'b0, "R9 held off by carrier", tx_en, 0);
        crs = 1'b0;
      end
    join
    wait_idle();
    chk(last_gap == 24, "R9 start 24 after carrier", last_gap, 24);

    // half duplex back-to-back with carrier inside the gap (R9)
    fill(3, 7); build(3, -1, -1);
    fork
      begin
        drive(3, -1, -1);
        fill(2, 8); build(2, -1, -1);
        drive(2, -1, -1);
      end
      begin
        wait (tx_en);
        wait (!tx_en);
        repeat (10) step();
        crs = 1'b1;
        repeat (5) step();
        crs = 1'b0;
      end
    join
    wait_idle();
    chk(last_gap == 24, "R9 gap restarted by carrier", last_gap, 24);
    chk(last_low > 24, "R9 carrier lengthened gap", last_low, 25);

    // stopped clock mid-frame (R11)
    full_duplex = 1'b1;
    fill(10, 9); build(10, -1, -1);
    fork
      drive(10, -1, -1);
      begin
        wait (tx_en);
        repeat (8) step();
        hold_txd = txd;
        hold_en  = tx_en;
        clk_run  = 1'b0;
        #300;
        chk(txd == hold_txd && tx_en == hold_en, "R11 outputs frozen", {tx_en, txd}, {hold_en, hold_txd});
        clk_run = 1'b1;
      end
    join
    wait_idle();
    chk(exp_q.size() == 0, "R11 stream complete", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule